// File: doc/BRIEF.md
# Hardware Lock Register Bank

This block is a memory-mapped bank of one-bit lock flags that several processors share to guard common resources. A processor claims a lock by reading its register: if the lock was free, the read returns 0 and the lock becomes taken in the same access. If the lock was already held, the read returns 1 and the caller retries. The holder releases the lock by writing 0 to the same register.

Two register-bus slave ports, A and B, give access to the bank. Each port has an address, a read enable, a write enable, write data and registered read data. Port B can be removed at build time. A read-only configuration word reports how many locks were built. A read-only state word shows the flags of the first 32 locks, so a debugger can see them without touching any lock.

Top module: `hw_lock_bank`

## Requirements
- R1: After the synchronous active-high reset, every lock is free and both read-data outputs are 0.
- R2: Offset 0x000 is a read-only configuration word. Bits 31:28 hold a count code: 1, 2, 3 or 4 for 32, 64, 128 or 256 locks (count = 1 << (4 + code)). All other bits are 0. Writes to it are ignored.
- R3: A read of lock register i (byte offset 0x100 + 4*i) while lock i is free returns 0 and leaves lock i taken.
- R4: A read of a lock register while the lock is taken returns 1 and leaves the lock taken.
- R5: Read data appears on the clock edge that follows the read enable. The read's effect on the lock takes place on that same edge, so a read in the next cycle sees the lock as taken. After a cycle with no read, the port's read data is 0.
- R6: Writing 0 to a lock register frees that lock. Writing any nonzero value to a lock register has no effect.
- R7: Offset 0x010 is a read-only state word. Bit n (n = 0..31) is 1 when lock n is taken. Locks 32 and above are not shown. Writes to it are ignored.
- R8: Unmapped offsets read as 0 and ignore writes. These are offsets past the last lock register, offsets that are not word-aligned, and all other unused space. Reads of unmapped offsets change no lock.
- R9: When both ports touch the same lock register in one cycle, port A wins. Port A's operation takes effect, port B's write does nothing, and port B's read returns 1 without claiming the lock.
- R10: When port B is disabled by its build parameter, its inputs have no effect and its read data stays 0.
- R11: When read enable and write enable are both high on one port, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_addr | input | ADDR_W | Port A byte address |
| a_rd_en | input | 1 | Port A read strobe |
| a_wr_en | input | 1 | Port A write strobe |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_addr | input | ADDR_W | Port B byte address |
| b_rd_en | input | 1 | Port B read strobe |
| b_wr_en | input | 1 | Port B write strobe |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
The hardest case to reach is two ports hitting one lock in the same cycle, because the result depends on exact alignment between both buses. The stimulus drives both ports from one cycle-level task, so a same-cycle double claim, a release on A against a claim on B, and a claim on A against a release on B are each placed on one exact edge. Each case is then followed by a plain read that shows which operation took hold. Locks above 31 are hidden from the state word, so their effect is proven by reading the state word for a clean value and then claiming the lock itself.

// File: rtl/hw_lock_pkg.sv
package hw_lock_pkg;

  // Fixed register offsets (bytes)
  localparam int CFG_OFS       = 'h000;
  localparam int STATE_OFS     = 'h010;
  localparam int LOCK_BASE_OFS = 'h100;

  typedef enum logic [1:0] {
    HIT_NONE  = 2'd0,
    HIT_CFG   = 2'd1,
    HIT_STATE = 2'd2,
    HIT_LOCK  = 2'd3
  } hit_e;

  // Count code reported in the top nibble of the configuration word
  function automatic logic [3:0] count_code(input int n);
    case (n)
      32:      return 4'd1;
      64:      return 4'd2;
      128:     return 4'd3;
      256:     return 4'd4;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/hw_lock_decode.sv
module hw_lock_decode
  import hw_lock_pkg::*;
#(
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 12,
  parameter int IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_e              hit,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(LOCK_BASE_OFS);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_LOCKS);

  logic [ADDR_W-1:0] rel;
  logic              in_window;

  // unsigned wrap folds the lower and upper bound into one compare
  assign rel       = addr - BASE;
  assign in_window = (rel < SPAN) && (rel[1:0] == 2'b00);

  always_comb begin
    hit = HIT_NONE;
    if (addr == ADDR_W'(CFG_OFS))        hit = HIT_CFG;
    else if (addr == ADDR_W'(STATE_OFS)) hit = HIT_STATE;
    else if (in_window)                  hit = HIT_LOCK;
  end

  always_comb begin
    idx = '0;
    for (int b = 0; b < IDX_W; b++) idx[b] = rel[b+2];
  end

endmodule

// File: rtl/hw_lock_arb.sv
module hw_lock_arb #(
  parameter int NUM_LOCKS = 32,
  parameter int IDX_W     = 5
) (
  input  logic [1:0]            claim,    // lock read request per port
  input  logic [1:0]            free,     // zero-write release per port
  input  logic [1:0]            touch,    // any lock access per port
  input  logic [1:0][IDX_W-1:0] idx,
  input  logic [NUM_LOCKS-1:0]  lock_q,
  output logic [NUM_LOCKS-1:0]  set_v,
  output logic [NUM_LOCKS-1:0]  clr_v,
  output logic [1:0]            held
);

  logic       collide;
  logic [1:0] grant;

  assign collide = touch[0] && touch[1] && (idx[0] == idx[1]);
  assign grant   = {~collide, 1'b1};

  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int p = 0; p < 2; p++) begin
      if (claim[p] && grant[p]) set_v[idx[p]] = 1'b1;
      if (free[p]  && grant[p]) clr_v[idx[p]] = 1'b1;
    end
  end

  // a losing port B read is reported as busy
  assign held[0] = lock_q[idx[0]];
  assign held[1] = collide | lock_q[idx[1]];

endmodule

// File: rtl/hw_lock_flags.sv
module hw_lock_flags #(
  parameter int NUM_LOCKS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LOCKS-1:0] set_v,
  input  logic [NUM_LOCKS-1:0] clr_v,
  output logic [NUM_LOCKS-1:0] lock_q
);

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           lock_q[i] <= 1'b0;
      else if (set_v[i]) lock_q[i] <= 1'b1;
      else if (clr_v[i]) lock_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank
  import hw_lock_pkg::*;
#(
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter bit PORT_B_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_rd_en,
  input  logic              a_wr_en,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_rd_en,
  input  logic              b_wr_en,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int IDX_W = $clog2(NUM_LOCKS);
  localparam logic [DATA_W-1:0] CFG_WORD =
    {count_code(NUM_LOCKS), {(DATA_W-4){1'b0}}};

  logic [1:0][ADDR_W-1:0] addr_p;
  logic [1:0][DATA_W-1:0] wd_p;
  logic [1:0]             rd_p, wr_p;
  hit_e                   hit_p [2];
  logic [1:0][IDX_W-1:0]  idx_p;
  logic [1:0]             is_lock_p, claim_p, free_p, touch_p, held_p;
  logic [1:0][DATA_W-1:0] rdata_q;
  logic [NUM_LOCKS-1:0]   lock_q, set_v, clr_v;

  // port gathering; port B is tied off when disabled
  assign addr_p[0] = a_addr;
  assign wd_p[0]   = a_wdata;
  assign rd_p[0]   = a_rd_en;
  assign wr_p[0]   = a_wr_en;
  assign addr_p[1] = b_addr;
  assign wd_p[1]   = b_wdata;
  assign rd_p[1]   = PORT_B_EN & b_rd_en;
  assign wr_p[1]   = PORT_B_EN & b_wr_en;

  for (genvar p = 0; p < 2; p++) begin : g_port
    hw_lock_decode #(
      .NUM_LOCKS(NUM_LOCKS),
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W)
    ) u_dec (
      .addr(addr_p[p]),
      .hit (hit_p[p]),
      .idx (idx_p[p])
    );

    assign is_lock_p[p] = (hit_p[p] == HIT_LOCK);
    assign claim_p[p]   = rd_p[p] && is_lock_p[p];
    // a read wins over a write on the same port
    assign free_p[p]    = wr_p[p] && !rd_p[p] && is_lock_p[p] && (wd_p[p] == '0);
    assign touch_p[p]   = (rd_p[p] || wr_p[p]) && is_lock_p[p];

    logic [DATA_W-1:0] rd_val;
    always_comb begin
      case (hit_p[p])
        HIT_CFG:   rd_val = CFG_WORD;
        HIT_STATE: rd_val = DATA_W'(lock_q[31:0]);
        HIT_LOCK:  rd_val = DATA_W'(held_p[p]);
        default:   rd_val = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst)           rdata_q[p] <= '0;
      else if (rd_p[p])  rdata_q[p] <= rd_val;
      else               rdata_q[p] <= '0;
    end
  end

  hw_lock_arb #(
    .NUM_LOCKS(NUM_LOCKS),
    .IDX_W    (IDX_W)
  ) u_arb (
    .claim (claim_p),
    .free  (free_p),
    .touch (touch_p),
    .idx   (idx_p),
    .lock_q(lock_q),
    .set_v (set_v),
    .clr_v (clr_v),
    .held  (held_p)
  );

  hw_lock_flags #(
    .NUM_LOCKS(NUM_LOCKS)
  ) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_v (set_v),
    .clr_v (clr_v),
    .lock_q(lock_q)
  );

  assign a_rdata = rdata_q[0];
  assign b_rdata = rdata_q[1];

endmodule

// File: rtl/hw_lock_bank_chk.sv
module hw_lock_bank_chk
  import hw_lock_pkg::*;
#(
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter bit PORT_B_EN = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    a_addr,
  input logic                 a_rd_en,
  input logic                 a_wr_en,
  input logic [DATA_W-1:0]    a_rdata,
  input logic                 b_rd_en,
  input logic                 b_wr_en,
  input logic [DATA_W-1:0]    b_rdata,
  input logic                 a_is_lock,
  input logic                 b_is_lock,
  input logic [IDX_W-1:0]     a_idx,
  input logic [IDX_W-1:0]     b_idx,
  input logic [NUM_LOCKS-1:0] lock_q
);

  localparam logic [DATA_W-1:0] CFG_WORD =
    {count_code(NUM_LOCKS), {(DATA_W-4){1'b0}}};

  // R3
  free_claim_chk: assert property (@(posedge clk) disable iff (rst)
    (a_rd_en && a_is_lock && !lock_q[a_idx]) |=> (a_rdata == '0 && lock_q[$past(a_idx)]));

  // R4
  busy_claim_chk: assert property (@(posedge clk) disable iff (rst)
    (a_rd_en && a_is_lock && lock_q[a_idx]) |=> (a_rdata == DATA_W'(1) && lock_q[$past(a_idx)]));

  // R2
  cfg_word_chk: assert property (@(posedge clk) disable iff (rst)
    (a_rd_en && a_addr == '0) |=> (a_rdata == CFG_WORD));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !a_rd_en |=> (a_rdata == '0));

  // R9
  b_loses_chk: assert property (@(posedge clk) disable iff (rst)
    (a_is_lock && (a_rd_en || a_wr_en) && b_is_lock && b_rd_en && a_idx == b_idx)
      |=> (b_rdata == DATA_W'(1)));

  // R6
  no_stray_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_rd_en && !b_rd_en) |=> ($countones(lock_q) <= $past($countones(lock_q))));

  // R11
  rd_over_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (a_rd_en && a_wr_en && a_is_lock) |=> lock_q[$past(a_idx)]);

  if (!PORT_B_EN) begin : g_b_off
    // R10
    b_silent_chk: assert property (@(posedge clk) disable iff (rst)
      (b_rdata == '0 && !b_wr_en));
  end

endmodule

bind hw_lock_bank hw_lock_bank_chk #(
  .NUM_LOCKS(NUM_LOCKS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .IDX_W    (IDX_W),
  .PORT_B_EN(PORT_B_EN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_addr   (a_addr),
  .a_rd_en  (a_rd_en),
  .a_wr_en  (a_wr_en),
  .a_rdata  (a_rdata),
  .b_rd_en  (rd_p[1]),
  .b_wr_en  (wr_p[1]),
  .b_rdata  (b_rdata),
  .a_is_lock(is_lock_p[0]),
  .b_is_lock(is_lock_p[1]),
  .a_idx    (idx_p[0]),
  .b_idx    (idx_p[1]),
  .lock_q   (lock_q)
);

// File: tb/hw_lock_bank_tb.sv
module hw_lock_bank_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] a_addr = '0, b_addr = '0;
  logic        a_rd_en = 1'b0, a_wr_en = 1'b0, b_rd_en = 1'b0, b_wr_en = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata, s_a_rdata, s_b_rdata;

  always #10 clk = ~clk;  // 50 MHz

  hw_lock_bank #(.NUM_LOCKS(64), .PORT_B_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_rd_en(a_rd_en), .a_wr_en(a_wr_en), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_rd_en(b_rd_en), .b_wr_en(b_wr_en), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  hw_lock_bank #(.NUM_LOCKS(32), .PORT_B_EN(1'b0)) u_dut_single (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_rd_en(a_rd_en), .a_wr_en(a_wr_en), .a_wdata(a_wdata), .a_rdata(s_a_rdata),
    .b_addr(b_addr), .b_rd_en(b_rd_en), .b_wr_en(b_wr_en), .b_wdata(b_wdata), .b_rdata(s_b_rdata)
  );

  typedef struct {
    int          unit;   // 0: A, 1: B, 2: single A, 3: single B
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;

  function automatic logic [11:0] lk(input int i);
    return 12'(32'h100 + 4 * i);
  endfunction

  task automatic drive(input logic ar, input logic aw, input logic [11:0] aa, input logic [31:0] ad,
                       input logic br, input logic bw, input logic [11:0] ba, input logic [31:0] bd);
    @(negedge clk);
    a_rd_en = ar; a_wr_en = aw; a_addr = aa; a_wdata = ad;
    b_rd_en = br; b_wr_en = bw; b_addr = ba; b_wdata = bd;
  endtask

  task automatic idle();
    drive(0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  task automatic expect_rd(input int unit, input logic [31:0] val, input string tag);
    exp_t e;
    e.unit = unit; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: results of the accesses driven before this edge
  always @(posedge clk) begin
    #5;
    while (q.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = q.pop_front();
      case (e.unit)
        0: act = a_rdata;
        1: act = b_rdata;
        2: act = s_a_rdata;
        default: act = s_b_rdata;
      endcase
      n_checks++;
      if (act !== e.val) begin
        n_errors++;
        $display("FAIL %s unit=%0d actual=%h expected=%h", e.tag, e.unit, act, e.val);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    idle();                                   expect_rd(0, 32'h0, "R1 reset A"); expect_rd(1, 32'h0, "R1 reset B");
    drive(1, 0, 12'h000, '0, 1, 0, 12'h010, '0);
    expect_rd(0, 32'h2000_0000, "R2 config 64"); expect_rd(1, 32'h0, "R1 state all free");
    expect_rd(2, 32'h1000_0000, "R2 config 32");
    drive(1, 0, lk(3), '0, 0, 0, '0, '0);     expect_rd(0, 32'h0, "R3 claim free");
    drive(1, 0, lk(3), '0, 0, 0, '0, '0);     expect_rd(0, 32'h1, "R5 back-to-back R4");
    idle();                                   expect_rd(0, 32'h0, "R5 idle zero");
    drive(1, 0, 12'h010, '0, 0, 0, '0, '0);   expect_rd(0, 32'h8, "R7 state bit3");
    drive(0, 1, lk(3), 32'h5, 0, 0, '0, '0);
    drive(1, 0, lk(3), '0, 0, 0, '0, '0);     expect_rd(0, 32'h1, "R6 nonzero write ignored");
    drive(0, 1, lk(3), '0, 0, 0, '0, '0);
    drive(1, 0, lk(3), '0, 0, 0, '0, '0);     expect_rd(0, 32'h0, "R6 release");
    drive(0, 1, lk(3), '0, 0, 0, '0, '0);
    drive(0, 0, '0, '0, 1, 0, lk(40), '0);    expect_rd(1, 32'h0, "R3 port B claim 40");
    drive(1, 0, 12'h010, '0, 0, 0, '0, '0);   expect_rd(0, 32'h0, "R7 lock 40 hidden");
    drive(1, 0, lk(40), '0, 0, 0, '0, '0);    expect_rd(0, 32'h1, "R4 taken by B");
    drive(1, 0, lk(63), '0, 1, 0, 12'h200, '0);
    expect_rd(0, 32'h0, "R8 last lock"); expect_rd(1, 32'h0, "R8 past end");
    drive(1, 0, 12'h200, '0, 1, 0, 12'h101, '0);
    expect_rd(0, 32'h0, "R8 past end again"); expect_rd(1, 32'h0, "R8 unaligned");
    drive(1, 0, lk(31), '0, 1, 0, lk(0), '0);
    expect_rd(0, 32'h0, "R3 lock31"); expect_rd(1, 32'h0, "R3 lock0");
    drive(0, 1, 12'h010, 32'hFFFF_FFFF, 0, 1, 12'h000, 32'hFFFF_FFFF);
    drive(1, 0, 12'h010, '0, 1, 0, 12'h000, '0);
    expect_rd(0, 32'h8000_0001, "R7 state read-only"); expect_rd(1, 32'h2000_0000, "R2 config read-only");
    drive(1, 0, lk(7), '0, 1, 0, lk(7), '0);
    expect_rd(0, 32'h0, "R9 A wins claim"); expect_rd(1, 32'h1, "R9 B loses claim");
    expect_rd(3, 32'h0, "R10 disabled B silent");
    drive(0, 1, lk(7), '0, 1, 0, lk(7), '0);  expect_rd(1, 32'h1, "R9 B claim vs A release");
    drive(1, 0, lk(7), '0, 0, 0, '0, '0);     expect_rd(0, 32'h0, "R9 A release took effect");
    drive(1, 0, lk(8), '0, 0, 1, lk(8), '0);  expect_rd(0, 32'h0, "R9 A claim vs B release");
    drive(0, 0, '0, '0, 1, 0, lk(8), '0);     expect_rd(1, 32'h1, "R9 B release suppressed");
    drive(1, 0, lk(10), '0, 1, 0, lk(11), '0);
    expect_rd(0, 32'h0, "R3 parallel A"); expect_rd(1, 32'h0, "R3 parallel B");
    drive(1, 1, lk(10), '0, 0, 0, '0, '0);    expect_rd(0, 32'h1, "R11 read wins");
    drive(1, 0, lk(10), '0, 0, 0, '0, '0);    expect_rd(0, 32'h1, "R11 lock kept");
    drive(1, 0, 12'h010, '0, 0, 0, '0, '0);   expect_rd(0, 32'h8000_0D81, "R7 final state");
    idle();
    idle();
    idle();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule